// File: doc/BRIEF.md
# Wideband Input Capture and Sync Routing Front End

This block sits at the head of one receive channel. It chooses one of two wideband input ports, each carrying a data word, an exponent and an input-enable line. It decides on which clocks a new sample from that port is taken into the channel. It also routes one of four external sync pins to the channel. A single control word sets all three choices.

There are three ways to capture. The every-clock modes take a sample on each clock. The rising-edge mode takes a sample only on the first clock after the selected enable line goes from low to high. The falling-edge mode takes a sample only on the first clock after that line goes from high to low.

Later filter stages keep running every clock. They always see the most recent captured sample, which is held between captures. A separate strobe tells the phase accumulator to advance, and it fires once for each newly captured sample.

Edge detection compares the enable line with a registered copy of itself. An enable level held for many clocks therefore yields exactly one capture. Any sync pin can serve any channel, so several channel instances may share one pin.

Top module: `wbcap_front`

## Requirements
- R1: With mode field `cfg_ctrl[1:0]` = 10 (rising-edge mode), a capture occurs on the first clock at which the selected enable is high after being low on the previous clock. `smp_valid` is high for that one cycle, and `smp_data`/`smp_exp` show the port's data and exponent as they were at that clock.
- R2: With mode field = 11 (falling-edge mode), a capture occurs on the first clock at which the selected enable is low after being high on the previous clock, with the same output timing as R1.
- R3: With mode field = 00 or 01 (every-clock modes), every clock captures the selected port's data and exponent, and `smp_valid` stays high.
- R4: `phase_adv` is high in exactly the cycles in which `smp_valid` is high. It pulses once per captured sample and never on a clock without a capture.
- R5: In an edge mode, an enable level held for several clocks produces only one capture. Between captures `smp_data` and `smp_exp` hold the last captured values, even when the port data changes.
- R6: Control bit 6 selects the port: 1 routes port B (data, exponent, enable) and 0 routes port A. Activity on the unselected port has no effect on any output.
- R7: Control bits 8:7 select the sync pin, one clock after the selection: 00 gives pin 0, 01 gives pin 1, 10 gives pin 2 and 11 gives pin 3.
- R8: A change of bit 6 takes effect on the next clock. That clock still captures from the old port in an every-clock mode, and produces no capture in an edge mode. The new port's enable level becomes the edge history, so the switch itself never counts as an edge.
- R9: While `rst_n` is low, all outputs are 0. The first clock after reset only loads the edge history and produces no edge-mode capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl | input | 9 | Control word: [1:0] capture mode, [6] port select, [8:7] sync select; other bits unused |
| pa_data | input | DATA_W | Port A data word |
| pa_exp | input | EXP_W | Port A exponent |
| pa_en | input | 1 | Port A input-enable |
| pb_data | input | DATA_W | Port B data word |
| pb_exp | input | EXP_W | Port B exponent |
| pb_en | input | 1 | Port B input-enable |
| sync_pins | input | N_SYNC | External sync pins |
| smp_data | output | DATA_W | Last captured data word |
| smp_exp | output | EXP_W | Last captured exponent |
| smp_valid | output | 1 | High for one cycle per captured sample |
| phase_adv | output | 1 | Phase-accumulator advance strobe |
| sync_out | output | 1 | Selected sync pin, registered |

## Verification
Every result of the block is registered. A capture decided at a clock edge shows on `smp_valid`, `phase_adv`, `smp_data` and `smp_exp` right after that same edge. A new sync selection or pin level shows on `sync_out` after one edge, and a port switch shows one edge after it is written.

The bench changes its inputs two nanoseconds after a rising edge. It then waits for the next rising edge and samples two nanoseconds later. Each check therefore looks at the outputs of the exact edge that consumed the stimulus, and never races the clock.

// File: rtl/wbcap_pkg.sv
package wbcap_pkg;

   typedef enum logic [1:0] {
      CAP_EVERY     = 2'b00,
      CAP_EVERY_ALT = 2'b01,
      CAP_RISE      = 2'b10,
      CAP_FALL      = 2'b11
   } cap_mode_e;

   localparam int unsigned CTRL_W     = 9;
   localparam int unsigned MODE_LSB   = 0;
   localparam int unsigned MODE_W     = 2;
   localparam int unsigned PORT_BIT   = 6;
   localparam int unsigned SYNC_LSB   = 7;
   localparam int unsigned SYNC_SEL_W = 2;

   function automatic logic is_edge_mode(cap_mode_e m);
      return m[1];
   endfunction

endpackage

// File: rtl/wbcap_port_mux.sv
module wbcap_port_mux #(
   parameter int unsigned DATA_W = 14,
   parameter int unsigned EXP_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_req,
   input  logic [DATA_W-1:0] a_data,
   input  logic [EXP_W-1:0]  a_exp,
   input  logic              a_en,
   input  logic [DATA_W-1:0] b_data,
   input  logic [EXP_W-1:0]  b_exp,
   input  logic              b_en,
   output logic              switching,
   output logic [DATA_W-1:0] cur_data,
   output logic [EXP_W-1:0]  cur_exp,
   output logic              cur_en,
   output logic              req_en
);

   logic port_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) port_q <= 1'b0;
      else        port_q <= port_req;
   end

   assign switching = (port_req != port_q);

   always_comb begin
      if (port_q) begin
         cur_data = b_data;
         cur_exp  = b_exp;
         cur_en   = b_en;
      end else begin
         cur_data = a_data;
         cur_exp  = a_exp;
         cur_en   = a_en;
      end
   end

   assign req_en = port_req ? b_en : a_en;

   // R8: after a switch the routed enable comes from the requested port
   p_switch_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
      switching |=> (port_q == $past(port_req)));

endmodule

// File: rtl/wbcap_edge_qual.sv
module wbcap_edge_qual
   import wbcap_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  cap_mode_e mode,
   input  logic      en_cur,
   input  logic      en_reload,
   input  logic      reload,
   output logic      take
);

   logic hist_q;
   logic primed_q;
   logic hist_ok;
   logic rise_hit;
   logic fall_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q   <= 1'b0;
         primed_q <= 1'b0;
      end else begin
         primed_q <= 1'b1;
         hist_q   <= reload ? en_reload : en_cur;
      end
   end

   assign hist_ok  = primed_q && !reload;
   assign rise_hit = hist_ok && en_cur && !hist_q;
   assign fall_hit = hist_ok && !en_cur && hist_q;

   always_comb begin
      unique case (mode)
         CAP_RISE: take = rise_hit;
         CAP_FALL: take = fall_hit;
         default:  take = 1'b1;
      endcase
   end

   // R5: an edge mode never captures on two clocks in a row
   p_edge_no_repeat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_edge_mode(mode) && take) |=> !(take && $stable(mode)));

   // R9: the first clock after reset gives no edge capture
   p_first_clock_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!primed_q && is_edge_mode(mode)) |-> !take);

endmodule

// File: rtl/wbcap_capture_reg.sv
module wbcap_capture_reg #(
   parameter int unsigned DATA_W = 14,
   parameter int unsigned EXP_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [DATA_W-1:0] d_data,
   input  logic [EXP_W-1:0]  d_exp,
   output logic [DATA_W-1:0] q_data,
   output logic [EXP_W-1:0]  q_exp,
   output logic              q_valid
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_data  <= '0;
         q_exp   <= '0;
         q_valid <= 1'b0;
      end else begin
         q_valid <= take;
         if (take) begin
            q_data <= d_data;
            q_exp  <= d_exp;
         end
      end
   end

   // R5: sample held between captures
   p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !q_valid |-> ($stable(q_data) && $stable(q_exp)));

endmodule

// File: rtl/wbcap_sync_sel.sv
module wbcap_sync_sel #(
   parameter int unsigned N_SYNC  = 4,
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned SEL_W  = (N_SYNC > 1) ? $clog2(N_SYNC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel,
   input  logic [N_SYNC-1:0] pins,
   output logic              sync_o
);

   logic picked;

   assign picked = pins[sel];

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_o <= 1'b0;
            else        sync_o <= picked;
         end

         // R7: output follows the chosen pin one clock later
         p_sync_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (sync_o == $past(pins[sel])));
      end else begin : g_comb
         assign sync_o = picked;
      end
   endgenerate

endmodule

// File: rtl/wbcap_front.sv
module wbcap_front
   import wbcap_pkg::*;
#(
   parameter int unsigned DATA_W   = 14,
   parameter int unsigned EXP_W    = 3,
   parameter int unsigned N_SYNC   = 4,
   parameter bit          SYNC_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [8:0]        cfg_ctrl,
   input  logic [DATA_W-1:0] pa_data,
   input  logic [EXP_W-1:0]  pa_exp,
   input  logic              pa_en,
   input  logic [DATA_W-1:0] pb_data,
   input  logic [EXP_W-1:0]  pb_exp,
   input  logic              pb_en,
   input  logic [N_SYNC-1:0] sync_pins,
   output logic [DATA_W-1:0] smp_data,
   output logic [EXP_W-1:0]  smp_exp,
   output logic              smp_valid,
   output logic              phase_adv,
   output logic              sync_out
);

   localparam int unsigned SEL_W = (N_SYNC > 1) ? $clog2(N_SYNC) : 1;

   generate
      if (DATA_W < 2)            begin : g_bad_data $error("DATA_W too small"); end
      if (EXP_W < 1)             begin : g_bad_exp  $error("EXP_W too small"); end
      if (N_SYNC != (1 << SYNC_SEL_W)) begin : g_bad_sync
         $error("N_SYNC must match the sync select field");
      end
      if (SEL_W != SYNC_SEL_W)   begin : g_bad_sel  $error("sync select width mismatch"); end
   endgenerate

   cap_mode_e             mode;
   logic                  port_req;
   logic [SEL_W-1:0]      sync_sel;
   logic                  switching;
   logic [DATA_W-1:0]     cur_data;
   logic [EXP_W-1:0]      cur_exp;
   logic                  cur_en;
   logic                  req_en;
   logic                  take;
   logic                  adv_q;
   logic                  unused_ctrl_bits;

   assign mode     = cap_mode_e'(cfg_ctrl[MODE_LSB +: MODE_W]);
   assign port_req = cfg_ctrl[PORT_BIT];
   assign sync_sel = cfg_ctrl[SYNC_LSB +: SEL_W];
   assign unused_ctrl_bits = ^cfg_ctrl[PORT_BIT-1:MODE_LSB+MODE_W];

   wbcap_port_mux #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .port_req  (port_req),
      .a_data    (pa_data),
      .a_exp     (pa_exp),
      .a_en      (pa_en),
      .b_data    (pb_data),
      .b_exp     (pb_exp),
      .b_en      (pb_en),
      .switching (switching),
      .cur_data  (cur_data),
      .cur_exp   (cur_exp),
      .cur_en    (cur_en),
      .req_en    (req_en)
   );

   wbcap_edge_qual u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .en_cur    (cur_en),
      .en_reload (req_en),
      .reload    (switching),
      .take      (take)
   );

   wbcap_capture_reg #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .d_data  (cur_data),
      .d_exp   (cur_exp),
      .q_data  (smp_data),
      .q_exp   (smp_exp),
      .q_valid (smp_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) adv_q <= 1'b0;
      else        adv_q <= take;
   end
   assign phase_adv = adv_q;

   wbcap_sync_sel #(.N_SYNC(N_SYNC), .REG_OUT(SYNC_REG)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sync_sel),
      .pins   (sync_pins),
      .sync_o (sync_out)
   );

   // R4: advance strobe and capture strobe agree
   p_adv_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
      phase_adv == smp_valid);

   // R8: a port switch in an edge mode yields no capture
   p_switch_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (switching && is_edge_mode(mode)) |=> !smp_valid);

   // R3: every-clock modes capture on each clock
   p_every_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !is_edge_mode(mode) |=> smp_valid);

endmodule

// File: tb/wbcap_front_tb_top.sv
module wbcap_front_tb_top;

   localparam int DATA_W = 14;
   localparam int EXP_W  = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [8:0]        cfg_ctrl = '0;
   logic [DATA_W-1:0] pa_data = '0;
   logic [EXP_W-1:0]  pa_exp = '0;
   logic              pa_en = 1'b0;
   logic [DATA_W-1:0] pb_data = '0;
   logic [EXP_W-1:0]  pb_exp = '0;
   logic              pb_en = 1'b0;
   logic [3:0]        sync_pins = '0;
   logic [DATA_W-1:0] smp_data;
   logic [EXP_W-1:0]  smp_exp;
   logic              smp_valid;
   logic              phase_adv;
   logic              sync_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   wbcap_front dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl),
      .pa_data(pa_data), .pa_exp(pa_exp), .pa_en(pa_en),
      .pb_data(pb_data), .pb_exp(pb_exp), .pb_en(pb_en),
      .sync_pins(sync_pins),
      .smp_data(smp_data), .smp_exp(smp_exp), .smp_valid(smp_valid),
      .phase_adv(phase_adv), .sync_out(sync_out)
   );

   function automatic logic [8:0] mk(logic [1:0] mode, logic port, logic [1:0] sy);
      return {sy, port, 4'b0000, mode};
   endfunction

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_cap(string req, logic v, logic [DATA_W-1:0] d);
      chk(req, "valid", 32'(smp_valid), 32'(v));
      chk(req, "adv (R4)", 32'(phase_adv), 32'(v));
      chk(req, "data", 32'(smp_data), 32'(d));
   endtask

   // R9: reset state, then the first clock gives no edge capture
   task automatic t_reset();
      cfg_ctrl = mk(2'b10, 1'b0, 2'b00);
      pa_en = 1'b1; pa_data = 14'h0123;
      #12;
      chk("R9", "valid in reset", 32'(smp_valid), 0);
      chk("R9", "data in reset", 32'(smp_data), 0);
      chk("R9", "sync in reset", 32'(sync_out), 0);
      step();
      rst_n = 1'b1;
      step();
      chk_cap("R9", 1'b0, '0);
      pa_en = 1'b0; step();
      chk_cap("R9", 1'b0, '0);
   endtask

   task automatic t_every();
      cfg_ctrl = mk(2'b00, 1'b0, 2'b00);
      pa_data = 14'h0050; pa_exp = 3'd5; step();
      chk_cap("R3", 1'b1, 14'h0050);
      chk("R3", "exp", 32'(smp_exp), 5);
      pa_data = 14'h0051; step();
      chk_cap("R3", 1'b1, 14'h0051);
      cfg_ctrl = mk(2'b01, 1'b0, 2'b00);
      pa_data = 14'h0052; step();
      chk_cap("R3", 1'b1, 14'h0052);
   endtask

   task automatic t_rise();
      cfg_ctrl = mk(2'b10, 1'b0, 2'b00);
      pa_en = 1'b0; step(); step();
      chk_cap("R1", 1'b0, 14'h0052);
      pa_en = 1'b1; pa_data = 14'h0155; pa_exp = 3'd2; step();
      chk_cap("R1", 1'b1, 14'h0155);
      chk("R1", "exp", 32'(smp_exp), 2);
      pa_data = 14'h00AA; pa_exp = 3'd7;
      for (int i = 0; i < 3; i++) begin
         step();
         chk_cap("R5", 1'b0, 14'h0155);
         chk("R5", "exp held", 32'(smp_exp), 2);
      end
      pa_en = 1'b0; step();
      chk_cap("R1", 1'b0, 14'h0155);
      pa_en = 1'b1; pa_data = 14'h003C; step();
      chk_cap("R1", 1'b1, 14'h003C);
   endtask

   task automatic t_fall();
      cfg_ctrl = mk(2'b11, 1'b0, 2'b00);
      step();
      chk_cap("R2", 1'b0, 14'h003C);
      pa_en = 1'b0; pa_data = 14'h0222; step();
      chk_cap("R2", 1'b1, 14'h0222);
      pa_data = 14'h0333; step();
      chk_cap("R5", 1'b0, 14'h0222);
      pa_en = 1'b1; step();
      chk_cap("R2", 1'b0, 14'h0222);
   endtask

   task automatic t_port_edge();
      cfg_ctrl = mk(2'b10, 1'b0, 2'b00);
      pa_en = 1'b0; step();
      pb_en = 1'b1; pb_data = 14'h0111; pb_exp = 3'd1;
      cfg_ctrl = mk(2'b10, 1'b1, 2'b00); step();
      chk_cap("R8", 1'b0, 14'h0222);
      step();
      chk_cap("R8", 1'b0, 14'h0222);
      pb_en = 1'b0; step();
      pb_en = 1'b1; pb_data = 14'h0777; pb_exp = 3'd6; step();
      chk_cap("R6", 1'b1, 14'h0777);
      chk("R6", "exp", 32'(smp_exp), 6);
      pa_en = 1'b0; step();
      pa_en = 1'b1; pa_data = 14'h0999; step();
      chk_cap("R6", 1'b0, 14'h0777);
   endtask

   task automatic t_port_every();
      cfg_ctrl = mk(2'b00, 1'b1, 2'b00);
      pa_data = 14'h0010; pb_data = 14'h0020; step();
      chk_cap("R6", 1'b1, 14'h0020);
      cfg_ctrl = mk(2'b00, 1'b0, 2'b00); step();
      chk_cap("R8", 1'b1, 14'h0020);
      step();
      chk_cap("R8", 1'b1, 14'h0010);
   endtask

   task automatic t_sync();
      for (int s = 0; s < 4; s++) begin
         cfg_ctrl = mk(2'b00, 1'b0, 2'(s));
         sync_pins = 4'(1 << s); step();
         chk("R7", "selected pin high", 32'(sync_out), 1);
         sync_pins = ~4'(1 << s); step();
         chk("R7", "selected pin low", 32'(sync_out), 0);
      end
   endtask

   initial begin
      t_reset();
      t_every();
      t_rise();
      t_fall();
      t_port_edge();
      t_port_every();
      t_sync();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule